// File: doc/BRIEF.md
# Privileged-Mode Dwell Monitor

This block watches the instruction retire stream of one core and measures how long execution stays in privileged mode without handing control back to user code. A trap handler damaged by a hardware fault often never returns to user mode. Normal kernel excursions, such as timer interrupt service, finish in well under ten thousand instructions. A run that goes past a threshold (30,000 by default) is therefore a strong sign of a fault.

Each cycle the monitor receives at most one retire, the privilege mode of that instruction, and a flag that says a system call is being serviced. System calls can legitimately run from a hundred thousand to a million instructions, so a run never builds up while that flag is high. When the run becomes longer than the threshold, a sticky symptom flag is raised and the run length at that point is captured. The flag stays set until an acknowledge input clears it. A recovery agent uses the flag to start diagnosis.

Top module: `os_dwell_monitor`

## Requirements
- R1: After reset, `symptom` is 0, `fire_count` is 0 and the internal run length is 0.
- R2: Each cycle with `retire_vld`=1, `priv_mode`=1 and `in_syscall`=0 lengthens the run by one. A cycle with `retire_vld`=0 and `in_syscall`=0 leaves the run unchanged.
- R3: A retire with `priv_mode`=0 (user mode) sets the run to zero.
- R4: In every cycle where `in_syscall`=1, the run is forced to zero, whether or not an instruction retires.
- R5: `symptom` rises in the cycle after the retire that makes the run equal to THRESH+1. A run of exactly THRESH never raises it.
- R6: When `symptom` is raised, `fire_count` takes the run length at that moment (THRESH+1). It holds that value until the next firing.
- R7: `symptom` stays at 1 until a cycle with `ack`=1, and it reads 0 from the following cycle. `ack` has no effect while `symptom` is 0.
- R8: If `ack`=1 in the same cycle as a firing retire, the firing wins and `symptom` is 1 afterwards.
- R9: A run fires at most once. The run saturates at THRESH+1, so further privileged retires after an `ack` do not raise `symptom` again until the run has been reset and crosses the threshold again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_vld | input | 1 | One instruction retires this cycle |
| priv_mode | input | 1 | Retiring instruction ran in privileged mode (1) or user mode (0) |
| in_syscall | input | 1 | A system call is being serviced |
| ack | input | 1 | Clears the symptom flag |
| symptom | output | 1 | Sticky excessive-privileged-run flag |
| fire_count | output | $clog2(THRESH+2) | Run length captured at the last firing |

## Verification
Clearing and firing can fall in the same cycle. The bench provokes this by holding `ack` high during the retire that takes the run from THRESH to THRESH+1. It then expects `symptom` to read 1 and `fire_count` to read THRESH+1 in the next cycle. A second case pairs `ack` with an ordinary privileged retire while the flag is set, and checks that the flag drops and does not come back.

// File: rtl/os_dwell_monitor.sv
module os_dwell_monitor #(
  parameter int unsigned THRESH = 30000,
  localparam int CW = $clog2(THRESH + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire_vld,
  input  logic          priv_mode,
  input  logic          in_syscall,
  input  logic          ack,
  output logic          symptom,
  output logic [CW-1:0] fire_count
);

  localparam logic [CW-1:0] LIMIT = CW'(THRESH + 1);

  logic [CW-1:0] run_cnt;

  wire kernel_step = retire_vld && priv_mode && !in_syscall;
  wire run_break   = in_syscall || (retire_vld && !priv_mode);
  wire saturated   = (run_cnt == LIMIT);
  wire crossing    = kernel_step && (run_cnt == LIMIT - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      run_cnt <= '0;
    else if (run_break)
      run_cnt <= '0;
    else if (kernel_step && !saturated)
      run_cnt <= run_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      symptom    <= 1'b0;
      fire_count <= '0;
    end else if (crossing) begin
      symptom    <= 1'b1;
      fire_count <= run_cnt + 1'b1;
    end else if (ack) begin
      symptom    <= 1'b0;
    end
  end

endmodule

module os_dwell_monitor_chk #(
  parameter int unsigned THRESH = 30000,
  localparam int CW = $clog2(THRESH + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          retire_vld,
  input logic          priv_mode,
  input logic          in_syscall,
  input logic          ack,
  input logic          symptom,
  input logic [CW-1:0] fire_count,
  input logic [CW-1:0] run_cnt
);

  assert_user_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && !priv_mode) |=> (run_cnt == '0));

  assert_syscall_holds_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_syscall |=> (run_cnt == '0));

  assert_idle_keeps_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_vld && !in_syscall) |=> $stable(run_cnt));

  assert_rise_needs_kernel_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(symptom) |-> $past(retire_vld && priv_mode && !in_syscall));

  assert_capture_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(symptom) |-> (fire_count == CW'(THRESH + 1)));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (symptom && !ack) |=> symptom);

  assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CW'(THRESH + 1));

endmodule

bind os_dwell_monitor os_dwell_monitor_chk #(.THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .priv_mode(priv_mode),
  .in_syscall(in_syscall), .ack(ack), .symptom(symptom),
  .fire_count(fire_count), .run_cnt(run_cnt)
);

// File: tb/test_os_dwell_monitor.sv
module test_os_dwell_monitor;
  localparam int unsigned TH = 20;
  localparam int W = $clog2(TH + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire_vld = 1'b0, priv_mode = 1'b0, in_syscall = 1'b0, ack = 1'b0;
  logic symptom;
  logic [W-1:0] fire_count;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  os_dwell_monitor #(.THRESH(TH)) i_os_dwell_monitor (
    .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .priv_mode(priv_mode),
    .in_syscall(in_syscall), .ack(ack), .symptom(symptom), .fire_count(fire_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int n, input logic pm, input logic sc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      retire_vld = 1'b1; priv_mode = pm; in_syscall = sc;
    end
    @(negedge clk);
    retire_vld = 1'b0; in_syscall = 1'b0;
  endtask

  task automatic idle(input int n, input logic sc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      retire_vld = 1'b0; in_syscall = sc;
    end
    @(negedge clk);
    in_syscall = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    run(1, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 symptom", symptom, 0);
    check("R1 fire_count", fire_count, 0);
    run(TH, 1'b1, 1'b0);
    check("R1 run starts at zero", symptom, 0);
    run(1, 1'b0, 1'b0);
  endtask

  task automatic t_threshold();
    run(TH, 1'b1, 1'b0);
    check("R5 exactly THRESH no fire", symptom, 0);
    run(1, 1'b1, 1'b0);
    check("R5 fires at THRESH+1", symptom, 1);
    check("R6 fire_count", fire_count, TH + 1);
    clear_all();
  endtask

  task automatic t_gaps();
    run(10, 1'b1, 1'b0);
    idle(7, 1'b0);
    run(10, 1'b1, 1'b0);
    check("R2 idle keeps run", symptom, 0);
    run(1, 1'b1, 1'b0);
    check("R2 run spans idle cycles", symptom, 1);
    clear_all();
  endtask

  task automatic t_user();
    run(TH, 1'b1, 1'b0);
    run(1, 1'b0, 1'b0);
    run(TH, 1'b1, 1'b0);
    check("R3 user retire restarts run", symptom, 0);
    run(1, 1'b1, 1'b0);
    check("R3 fires after fresh run", symptom, 1);
    clear_all();
  endtask

  task automatic t_syscall();
    run(50, 1'b1, 1'b1);
    check("R4 syscall retires not counted", symptom, 0);
    run(15, 1'b1, 1'b0);
    idle(1, 1'b1);
    run(TH, 1'b1, 1'b0);
    check("R4 syscall without retire zeroes run", symptom, 0);
    run(1, 1'b1, 1'b0);
    check("R4 fires after syscall ends", symptom, 1);
    clear_all();
  endtask

  task automatic t_sticky();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R7 ack while clear", symptom, 0);
    run(TH + 1, 1'b1, 1'b0);
    idle(5, 1'b0);
    check("R7 sticky", symptom, 1);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R7 ack clears", symptom, 0);
    check("R6 fire_count kept after ack", fire_count, TH + 1);
    run(30, 1'b1, 1'b0);
    check("R9 no refire in same run", symptom, 0);
    run(1, 1'b0, 1'b0);
    run(TH + 1, 1'b1, 1'b0);
    check("R9 new run fires again", symptom, 1);
    clear_all();
  endtask

  task automatic t_collide();
    run(TH, 1'b1, 1'b0);
    @(negedge clk);
    retire_vld = 1'b1; priv_mode = 1'b1; ack = 1'b1;
    @(negedge clk);
    retire_vld = 1'b0; ack = 1'b0;
    check("R8 set wins over ack", symptom, 1);
    check("R8 fire_count", fire_count, TH + 1);
    @(negedge clk);
    retire_vld = 1'b1; priv_mode = 1'b1; ack = 1'b1;
    @(negedge clk);
    retire_vld = 1'b0; ack = 1'b0;
    check("R8 ack with plain retire clears", symptom, 0);
    idle(3, 1'b0);
    check("R9 stays clear", symptom, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_gaps();
    t_user();
    t_syscall();
    t_sticky();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule